// File: doc/BRIEF.md
# Compute Queue Slot Scheduler

This block sits between the software-facing queue submission path and a group of compute dispatch engines. Software hands it queue descriptors, each made of a queue identifier and a priority. Every engine owns a fixed number of queue slots, and a slot holds one active queue until the engine gives it back. Descriptors that arrive while every slot is occupied wait in an internal holding buffer.

As soon as any slot is free and the buffer holds at least one descriptor, the block assigns one queue per cycle, without any extra wait state. It keeps going until the buffer is empty or no slot is left. The buffered queue chosen is the one with the highest priority; among equal priorities, the one that arrived first goes first. The slot chosen is the lowest free slot of the lowest-numbered engine that has one.

Queues that already sit in a slot are never displaced. A high-priority arrival only goes ahead of other waiting queues.

Top module: `cq_assign_sched`

## Requirements
- R1: After reset, `asg_valid` is 0 and `sub_ready` is 1, and every slot of every engine is free. The first queue submitted goes to engine 0, slot 0.
- R2: A slot holds at most one queue. With 8 engines of 8 slots, at most 64 queues are active at once. Once all slots are occupied, `asg_valid` stays 0 until a slot is released.
- R3: When a descriptor is accepted (`sub_valid` and `sub_ready` at a rising edge) and a slot is free, the assignment appears on `asg_*` in the very next cycle. At most one assignment is made per cycle, and each cycle with `asg_valid` high consumes that assignment.
- R4: Among buffered descriptors, the one with the largest `sub_prio` value is assigned first. A value of 3 is the highest priority and 0 the lowest.
- R5: Buffered descriptors of equal priority are assigned in the order they were accepted.
- R6: The buffer holds 16 descriptors. `sub_ready` is 0 while 16 are held, and a `sub_valid` pulse during that time is ignored and never assigned. `sub_ready` returns to 1 in the cycle after an assignment frees a buffer entry.
- R7: The target is the lowest-numbered engine that has a free slot, and within that engine the lowest-numbered free slot. `asg_eng` and `asg_slot` give these as binary numbers.
- R8: `rel_valid[e]` with slot number `rel_slot[3e+2:3e]` frees that slot of engine e at the rising edge, and the slot can be assigned in the following cycle. Releasing a slot that is already free has no effect.
- R9: Buffered descriptors are drained on consecutive cycles while slots remain free. Several releases in the same cycle lead to one assignment per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| sub_valid | input | 1 | Queue descriptor offered |
| sub_ready | output | 1 | Buffer can accept a descriptor |
| sub_prio | input | 2 | Priority of the offered queue, 3 highest |
| sub_qid | input | 8 | Identifier of the offered queue |
| rel_valid | input | 8 | Per-engine slot release strobe |
| rel_slot | input | 24 | Per-engine released slot number, 3 bits per engine, engine 0 in the low bits |
| asg_valid | output | 1 | An assignment is made this cycle |
| asg_qid | output | 8 | Identifier of the assigned queue |
| asg_eng | output | 3 | Engine receiving the queue |
| asg_slot | output | 3 | Slot within that engine |

## Verification
The bench builds the block with its default parameters: 8 engines of 8 slots, a 16-entry buffer and 2-bit priorities. With these values, 64 submissions fill every slot, and 16 more fill the buffer. Both the held state and the back-pressure state are therefore reached in a few hundred cycles. From a fully occupied machine, single releases make the chosen queue land in a slot known in advance, so the priority and arrival ordering can be observed one queue at a time. Releases in the same cycle expose the choice of lowest engine and the drain of one queue per cycle.

// File: rtl/cq_pkg.sv
package cq_pkg;

  parameter int CQ_PRIO_W = 2;
  parameter int CQ_QID_W  = 8;

  typedef struct packed {
    logic [CQ_PRIO_W-1:0] prio;
    logic [CQ_QID_W-1:0]  qid;
  } cq_desc_t;

endpackage

// File: rtl/cq_lowest_one.sv
module cq_lowest_one #(
  parameter  int W  = 8,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);

  always_comb begin
    found = |vec;
    idx   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end

endmodule

// File: rtl/cq_order_buf.sv
module cq_order_buf
  import cq_pkg::*;
#(
  parameter  int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                push,
  input  cq_desc_t            push_desc,
  input  logic                pop,
  output logic                ready,
  output logic                head_valid,
  output logic [CQ_QID_W-1:0] head_qid
);

  // entries kept packed toward index 0, oldest at 0
  cq_desc_t             ent_q [DEPTH];
  cq_desc_t             ent_d [DEPTH];
  logic [CNT_W-1:0]     cnt_q, cnt_d, cnt_after;
  logic                 ent_en;

  logic [IDX_W-1:0]     sel_idx;
  logic [CQ_PRIO_W-1:0] sel_prio;
  logic                 sel_found;

  // highest priority wins; scanning downward with >= leaves the oldest
  always_comb begin
    sel_idx   = '0;
    sel_prio  = '0;
    sel_found = 1'b0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (CNT_W'(i) < cnt_q && (!sel_found || ent_q[i].prio >= sel_prio)) begin
        sel_found = 1'b1;
        sel_prio  = ent_q[i].prio;
        sel_idx   = IDX_W'(i);
      end
    end
  end

  assign head_valid = (cnt_q != '0);
  assign head_qid   = ent_q[sel_idx].qid;
  assign ready      = (cnt_q < CNT_W'(DEPTH));
  assign ent_en     = push | pop;

  always_comb begin
    ent_d = ent_q;
    if (pop) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        if (i >= int'(sel_idx)) ent_d[i] = ent_q[i+1];
      end
    end
    cnt_after = cnt_q - CNT_W'(pop);
    if (push) ent_d[cnt_after[IDX_W-1:0]] = push_desc;
    cnt_d = cnt_after + CNT_W'(push);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (ent_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk) begin
    if (ent_en) ent_q <= ent_d;
  end

  // R6: occupancy never exceeds the buffer depth
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));

  // R6: the parent only pushes while space is reported
  a_r6_push_needs_room: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> ready);

  // R3: the parent only pops a present entry
  a_r3_pop_needs_entry: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> head_valid);

endmodule

// File: rtl/cq_slot_map.sv
module cq_slot_map #(
  parameter  int NUM_ENG = 8,
  parameter  int SLOTS   = 8,
  localparam int ENG_W   = $clog2(NUM_ENG),
  localparam int SLOT_W  = $clog2(SLOTS),
  localparam int TOTAL   = NUM_ENG * SLOTS,
  localparam int FLAT_W  = ENG_W + SLOT_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      claim,
  input  logic [NUM_ENG-1:0]        rel_valid,
  input  logic [NUM_ENG*SLOT_W-1:0] rel_slot,
  output logic                      any_free,
  output logic [ENG_W-1:0]          tgt_eng,
  output logic [SLOT_W-1:0]         tgt_slot
);

  logic [TOTAL-1:0]   busy_q, busy_d;
  logic               busy_en;
  logic [NUM_ENG-1:0] eng_has;
  logic [SLOT_W-1:0]  eng_slot [NUM_ENG];
  logic [FLAT_W-1:0]  tgt_flat;

  for (genvar e = 0; e < NUM_ENG; e++) begin : g_eng
    cq_lowest_one #(.W(SLOTS)) u_free (
      .vec   (~busy_q[e*SLOTS +: SLOTS]),
      .found (eng_has[e]),
      .idx   (eng_slot[e])
    );

    // R8: a release of an occupied slot frees it for the next cycle
    a_r8_release_frees: assert property (@(posedge clk) disable iff (!rst_n)
      (rel_valid[e] && busy_q[{ENG_W'(e), rel_slot[e*SLOT_W +: SLOT_W]}])
      |=> !busy_q[{ENG_W'(e), $past(rel_slot[e*SLOT_W +: SLOT_W])}]);
  end

  cq_lowest_one #(.W(NUM_ENG)) u_eng (
    .vec   (eng_has),
    .found (any_free),
    .idx   (tgt_eng)
  );

  assign tgt_slot = eng_slot[tgt_eng];
  assign tgt_flat = {tgt_eng, tgt_slot};
  assign busy_en  = claim | (|rel_valid);

  always_comb begin
    busy_d = busy_q;
    for (int e = 0; e < NUM_ENG; e++) begin
      if (rel_valid[e]) busy_d[{ENG_W'(e), rel_slot[e*SLOT_W +: SLOT_W]}] = 1'b0;
    end
    if (claim) busy_d[tgt_flat] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       busy_q <= '0;
    else if (busy_en) busy_q <= busy_d;
  end

  // R2: a claim is only made when a slot is free
  a_r2_claim_needs_free: assert property (@(posedge clk) disable iff (!rst_n)
    claim |-> any_free);

  // R2: the claimed slot is occupied afterwards
  a_r2_claim_occupies: assert property (@(posedge clk) disable iff (!rst_n)
    claim |=> busy_q[$past(tgt_flat)]);

endmodule

// File: rtl/cq_assign_sched.sv
module cq_assign_sched
  import cq_pkg::*;
#(
  parameter  int NUM_ENG = 8,
  parameter  int SLOTS   = 8,
  parameter  int DEPTH   = 16,
  localparam int ENG_W   = $clog2(NUM_ENG),
  localparam int SLOT_W  = $clog2(SLOTS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sub_valid,
  output logic                      sub_ready,
  input  logic [CQ_PRIO_W-1:0]      sub_prio,
  input  logic [CQ_QID_W-1:0]       sub_qid,
  input  logic [NUM_ENG-1:0]        rel_valid,
  input  logic [NUM_ENG*SLOT_W-1:0] rel_slot,
  output logic                      asg_valid,
  output logic [CQ_QID_W-1:0]       asg_qid,
  output logic [ENG_W-1:0]          asg_eng,
  output logic [SLOT_W-1:0]         asg_slot
);

  logic     push, pop;
  logic     head_valid;
  logic     any_free;
  cq_desc_t new_desc;

  assign new_desc  = '{prio: sub_prio, qid: sub_qid};
  assign push      = sub_valid & sub_ready;
  assign pop       = head_valid & any_free;
  assign asg_valid = pop;

  cq_order_buf #(.DEPTH(DEPTH)) u_buf (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (push),
    .push_desc  (new_desc),
    .pop        (pop),
    .ready      (sub_ready),
    .head_valid (head_valid),
    .head_qid   (asg_qid)
  );

  cq_slot_map #(.NUM_ENG(NUM_ENG), .SLOTS(SLOTS)) u_map (
    .clk       (clk),
    .rst_n     (rst_n),
    .claim     (pop),
    .rel_valid (rel_valid),
    .rel_slot  (rel_slot),
    .any_free  (any_free),
    .tgt_eng   (asg_eng),
    .tgt_slot  (asg_slot)
  );

  // R3: a lone accepted queue with a slot free is assigned the next cycle
  a_r3_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !head_valid && any_free) |=> asg_valid);

  // R2: with every slot taken and nothing released, nothing is assigned
  a_r2_hold_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_free && rel_valid == '0) |=> !asg_valid);

endmodule

// File: tb/sim_cq_assign_sched.sv
`timescale 1ns/1ps
module sim_cq_assign_sched;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sub_valid;
  logic        sub_ready;
  logic [1:0]  sub_prio;
  logic [7:0]  sub_qid;
  logic [7:0]  rel_valid;
  logic [23:0] rel_slot;
  logic        asg_valid;
  logic [7:0]  asg_qid;
  logic [2:0]  asg_eng;
  logic [2:0]  asg_slot;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  cq_assign_sched u0 (
    .clk(clk), .rst_n(rst_n), .sub_valid(sub_valid), .sub_ready(sub_ready),
    .sub_prio(sub_prio), .sub_qid(sub_qid), .rel_valid(rel_valid),
    .rel_slot(rel_slot), .asg_valid(asg_valid), .asg_qid(asg_qid),
    .asg_eng(asg_eng), .asg_slot(asg_slot)
  );

  // stimulus row: submitted priority and id, slot released later, id expected there
  typedef struct packed {
    logic [1:0] prio;
    logic [7:0] qid;
    logic [2:0] reng;
    logic [2:0] rslot;
    logic [7:0] exp_qid;
  } vec_t;

  localparam vec_t TBL [8] = '{
    '{2'd1, 8'd100, 3'd5, 3'd2, 8'd101},
    '{2'd3, 8'd101, 3'd0, 3'd0, 8'd103},
    '{2'd0, 8'd102, 3'd7, 3'd7, 8'd106},
    '{2'd3, 8'd103, 3'd3, 3'd1, 8'd104},
    '{2'd2, 8'd104, 3'd1, 3'd6, 8'd100},
    '{2'd1, 8'd105, 3'd6, 3'd3, 8'd105},
    '{2'd3, 8'd106, 3'd4, 3'd4, 8'd102},
    '{2'd0, 8'd107, 3'd2, 3'd5, 8'd107}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic expect_asg(input string req, input int qid, input int e, input int s);
    chk(req, "asg_valid", int'(asg_valid), 1);
    chk(req, "asg_qid",   int'(asg_qid), qid);
    chk(req, "asg_eng",   int'(asg_eng), e);
    chk(req, "asg_slot",  int'(asg_slot), s);
  endtask

  task automatic submit(input int prio, input int qid);
    @(negedge clk);
    sub_valid = 1'b1;
    sub_prio  = prio[1:0];
    sub_qid   = qid[7:0];
    @(negedge clk);
    sub_valid = 1'b0;
    #1;
  endtask

  task automatic release_slot(input int e, input int s);
    @(negedge clk);
    rel_valid[e]        = 1'b1;
    rel_slot[e*3 +: 3]  = s[2:0];
    @(negedge clk);
    rel_valid = '0;
    #1;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n     = 1'b0;
    sub_valid = 1'b0;
    sub_prio  = '0;
    sub_qid   = '0;
    rel_valid = '0;
    rel_slot  = '0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "asg_valid in reset", int'(asg_valid), 0);
    chk("R1", "sub_ready in reset", int'(sub_ready), 1);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1", "asg_valid after reset", int'(asg_valid), 0);

    // R7 R3: fill every slot; each lands the next cycle in lowest engine/slot
    for (int k = 0; k < 64; k++) begin
      submit(0, k);
      expect_asg("R7", k, k / 8, k % 8);
    end
    @(negedge clk); #1;
    chk("R2", "asg_valid when all slots taken", int'(asg_valid), 0);

    // R4 R5: buffer the table while full, nothing may be assigned
    for (int i = 0; i < 8; i++) begin
      submit(int'(TBL[i].prio), int'(TBL[i].qid));
      chk("R2", "held while full", int'(asg_valid), 0);
      chk("R6", "sub_ready below depth", int'(sub_ready), 1);
    end
    // R4 R5 R8: each release admits exactly the highest-priority, oldest entry
    for (int i = 0; i < 8; i++) begin
      release_slot(int'(TBL[i].reng), int'(TBL[i].rslot));
      expect_asg("R4", int'(TBL[i].exp_qid), int'(TBL[i].reng), int'(TBL[i].rslot));
      @(negedge clk); #1;
      chk("R2", "one assignment per release", int'(asg_valid), 0);
    end

    // R6: fill the buffer, then an offer while not ready is dropped
    for (int k = 0; k < 16; k++) submit(0, 200 + k);
    chk("R6", "sub_ready with 16 held", int'(sub_ready), 0);
    submit(0, 250);
    chk("R6", "sub_ready after refused offer", int'(sub_ready), 0);

    // R7 R9: two releases in one cycle, lowest engine first, then the other
    @(negedge clk);
    rel_valid           = 8'b1000_0100;
    rel_slot[2*3 +: 3]  = 3'd4;
    rel_slot[7*3 +: 3]  = 3'd0;
    @(negedge clk);
    rel_valid = '0;
    #1;
    expect_asg("R7", 200, 2, 4);
    chk("R6", "sub_ready before pop", int'(sub_ready), 0);
    @(negedge clk); #1;
    expect_asg("R9", 201, 7, 0);
    chk("R6", "sub_ready after pop", int'(sub_ready), 1);
    @(negedge clk); #1;
    chk("R9", "drained to empty slots", int'(asg_valid), 0);

    // R5: remaining equal-priority entries leave in arrival order
    for (int k = 0; k < 14; k++) begin
      int e = (k < 8) ? 1 : 6;
      int s = (k < 8) ? k : k - 8;
      release_slot(e, s);
      expect_asg("R5", 202 + k, e, s);
    end

    // R6: the refused id 250 must never appear
    release_slot(3, 3);
    chk("R6", "dropped offer not assigned", int'(asg_valid), 0);

    // R8: releasing an already free slot frees nothing else
    release_slot(3, 3);
    chk("R8", "asg_valid after free release", int'(asg_valid), 0);
    submit(2, 60);
    expect_asg("R8", 60, 3, 3);
    submit(1, 61);
    chk("R8", "no extra slot freed", int'(asg_valid), 0);
    release_slot(0, 5);
    expect_asg("R8", 61, 0, 5);

    // R1: reset mid-run empties all slots
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1", "asg_valid in second reset", int'(asg_valid), 0);
    chk("R1", "sub_ready in second reset", int'(sub_ready), 1);
    @(negedge clk);
    rst_n = 1'b1;
    submit(3, 77);
    expect_asg("R1", 77, 0, 0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule